// File: doc/BRIEF.md
# Configuration RAM Index Port with Interrupt Mask

This block sits on a byte-wide I/O bus and fronts a small configuration RAM through an index/data register pair. A write to the index port selects a RAM location and, in the same byte, sets or clears the mask that gates the processor's non-maskable interrupt line. A later access to the data port reads or writes the RAM byte at the selected location.

The mask bit is write-only during normal operation. A plain read of the index port returns all ones. An alias port returns the index with its top bit forced low. Only while an alternate-access mode is active does the index port return the real mask together with the index.

The block also watches the access order. Software is expected to follow each index write with a data-port access. If any other port access comes first, the block raises a sticky warning flag. Interrupt requests that arrive while the mask is set are held pending. They reach the output once the mask clears.

Top module: `cmos_idx_port`

## Requirements
- R1: After reset the mask is set (interrupt blocked), the latched index is 0, every RAM byte is 0x00, `nmi_out` is 0 and `seq_warn` is 0.
- R2: Every write to the index port (0x70) takes effect at the clock edge. Data bit 7 becomes the mask (1 blocks, 0 passes), and data bits 6:0 become the latched index (bit 6 reserved, bits 5:0 the RAM address).
- R3: With the alternate-access mode off, a read of the index port returns 0xFF, whatever was last written.
- R4: A read of the alias port (0x74) returns 0 in bit 7 and the latched index bits 6:0 in bits 6:0.
- R5: `alt_mode_en` is sampled at the clock edge. From the next cycle on, a read of the index port returns the mask in bit 7 and the latched index in bits 6:0.
- R6: A write to the data port (0x71) stores the byte at RAM address index[5:0]. A read of the data port returns that byte combinationally while `io_rd` is high. Index bit 6 does not change the address.
- R7: `nmi_req` is registered into a pending flag. `nmi_out` is the pending flag while the mask is 0 and is 0 while the mask is 1. A request seen while masked stays pending and is delivered in the cycle after the mask clears.
- R8: When an index-port write is followed by an access to any port other than the data port, `seq_warn` goes to 1 at that access's clock edge and stays at 1 until reset. A data-port access after the index write keeps `seq_warn` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, acts at the clock edge |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, combinational (0x00 for undecoded ports) |
| alt_mode_en | input | 1 | Alternate-access mode request |
| nmi_req | input | 1 | Incoming interrupt request |
| nmi_out | output | 1 | Gated interrupt to the processor |
| seq_warn | output | 1 | Sticky access-order warning |

## Verification
The hardest case to reach is a request that arrived while masked and is still pending when the mask clears. No port shows the pending flag, so the stimulus raises `nmi_req` for one masked cycle and drops it again. It then clears the mask with an index write and samples `nmi_out` for one cycle. The output must pulse for exactly that cycle. The order warning can only be tested once per run, because it is sticky. For that reason every earlier sequence follows its index write with a data access, and the deliberate violation comes last.

// File: rtl/cmos_idx_port.sv
module cmos_idx_port #(
  parameter int AW         = 8,
  parameter int RAM_AW     = 6,
  parameter logic [AW-1:0] IDX_PORT   = 8'h70,
  parameter logic [AW-1:0] DATA_PORT  = 8'h71,
  parameter logic [AW-1:0] ALIAS_PORT = 8'h74
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic [7:0]    io_wdata,
  input  logic          io_wr,
  input  logic          io_rd,
  output logic [7:0]    io_rdata,
  input  logic          alt_mode_en,
  input  logic          nmi_req,
  output logic          nmi_out,
  output logic          seq_warn
);
  localparam int DEPTH = 1 << RAM_AW;

  logic [6:0] idx_q;
  logic       mask_q;
  logic       alt_q;
  logic       pend_q;
  logic       expect_q;
  logic       warn_q;
  logic [7:0] mem [DEPTH];

  wire hit_idx   = (io_addr == IDX_PORT);
  wire hit_data  = (io_addr == DATA_PORT);
  wire hit_alias = (io_addr == ALIAS_PORT);
  wire access    = io_rd | io_wr;
  wire [RAM_AW-1:0] ram_a = idx_q[RAM_AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      mask_q <= 1'b1;
    end else if (io_wr && hit_idx) begin
      idx_q  <= io_wdata[6:0];
      mask_q <= io_wdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alt_q <= 1'b0;
    else        alt_q <= alt_mode_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (io_wr && hit_data) begin
      mem[ram_a] <= io_wdata;
    end
  end

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd) begin
      if (hit_idx)        io_rdata = alt_q ? {mask_q, idx_q} : 8'hFF;
      else if (hit_alias) io_rdata = {1'b0, idx_q};
      else if (hit_data)  io_rdata = mem[ram_a];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= nmi_req | (pend_q & mask_q);
  end

  assign nmi_out = pend_q & ~mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expect_q <= 1'b0;
      warn_q   <= 1'b0;
    end else if (access) begin
      if (expect_q && !hit_data) warn_q <= 1'b1;
      expect_q <= io_wr && hit_idx;
    end
  end

  assign seq_warn = warn_q;
endmodule

module cmos_idx_port_chk #(
  parameter int AW = 8,
  parameter logic [AW-1:0] IDX_PORT   = 8'h70,
  parameter logic [AW-1:0] DATA_PORT  = 8'h71,
  parameter logic [AW-1:0] ALIAS_PORT = 8'h74
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] io_addr,
  input logic [7:0]    io_wdata,
  input logic          io_wr,
  input logic          io_rd,
  input logic [7:0]    io_rdata,
  input logic          alt_mode_en,
  input logic          nmi_out,
  input logic          seq_warn
);
  // R7
  mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == IDX_PORT && io_wdata[7]) |=> !nmi_out);
  // R3
  idx_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == IDX_PORT && !alt_mode_en && !$past(alt_mode_en)) |-> io_rdata == 8'hFF);
  // R4
  alias_top_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == ALIAS_PORT) |-> !io_rdata[7]);
  // R8
  warn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_warn |=> seq_warn);
  // R6
  data_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == DATA_PORT) |=>
      ((io_rd && io_addr == DATA_PORT) -> io_rdata == $past(io_wdata)));
endmodule

bind cmos_idx_port cmos_idx_port_chk #(
  .AW(AW), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT), .ALIAS_PORT(ALIAS_PORT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
  .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
  .alt_mode_en(alt_mode_en), .nmi_out(nmi_out), .seq_warn(seq_warn)
);

// File: tb/cmos_idx_port_tb.sv
module cmos_idx_port_tb_top;
  localparam int PER = 10;
  localparam logic [7:0] PI = 8'h70, PD = 8'h71, PA = 8'h74;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] io_addr = '0, io_wdata = '0;
  logic io_wr = 1'b0, io_rd = 1'b0, alt_mode_en = 1'b0, nmi_req = 1'b0;
  logic [7:0] io_rdata;
  logic nmi_out, seq_warn;
  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(PER/2) clk = ~clk;

  cmos_idx_port dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .alt_mode_en(alt_mode_en), .nmi_req(nmi_req),
    .nmi_out(nmi_out), .seq_warn(seq_warn)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always begin
    @(negedge clk);
    #(PER/4);
    if (io_rd) begin
      if (exp_q.size() == 0) chk(io_rdata, 8'hxx, "monitor: unexpected read");
      else chk(io_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic sample_bit(input logic got, input logic exp, input string tag);
    #(PER/4);
    chk({7'd0, got}, {7'd0, exp}, tag);
  endtask

  initial begin
    #(PER*100000);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sample_bit(nmi_out, 1'b0, "R1 nmi_out after reset");
    sample_bit(seq_warn, 1'b0, "R1 seq_warn after reset");
    rd(PI, 8'hFF, "R3 index read after reset");
    rd(PA, 8'h00, "R1 R4 alias index zero after reset");
    rd(PD, 8'h00, "R1 RAM zero after reset");

    // R7 masked request held pending
    @(negedge clk); nmi_req = 1'b1;
    @(negedge clk); nmi_req = 1'b0;
    sample_bit(nmi_out, 1'b0, "R7 masked request blocked");
    wr(PI, 8'h0D);
    sample_bit(nmi_out, 1'b1, "R7 pending delivered on unmask");
    @(negedge clk);
    sample_bit(nmi_out, 1'b0, "R7 pending cleared after delivery");
    rd(PD, 8'h00, "R6 data read after index write");
    // R7 unmasked request passes after one register
    @(negedge clk); nmi_req = 1'b1;
    @(negedge clk);
    sample_bit(nmi_out, 1'b1, "R7 unmasked request passes");
    wr(PI, 8'h8D);
    sample_bit(nmi_out, 1'b0, "R2 R7 mask set blocks held request");
    rd(PD, 8'h00, "R6 data read after mask write");
    @(negedge clk); nmi_req = 1'b0;

    // R5 alternate access
    @(negedge clk); alt_mode_en = 1'b1;
    rd(PI, 8'h8D, "R5 alt read shows mask set");
    wr(PI, 8'h0D);
    rd(PD, 8'h00, "R6 data read");
    rd(PI, 8'h0D, "R2 R5 alt read shows mask clear");
    @(negedge clk); alt_mode_en = 1'b0;
    rd(PI, 8'hFF, "R3 index read ones with mask clear");

    // R6 RAM accesses
    wr(PI, 8'h05); wr(PD, 8'hA5);
    wr(PI, 8'h3F); wr(PD, 8'h5A);
    wr(PI, 8'h05); rd(PD, 8'hA5, "R6 readback address 5");
    wr(PI, 8'h3F); rd(PD, 8'h5A, "R6 readback address 63");
    wr(PI, 8'hC5); rd(PD, 8'hA5, "R6 reserved bit ignored for address");
    rd(PA, 8'h45, "R4 alias returns index bits with top low");
    rd(PI, 8'hFF, "R3 index read ones with mask set");
    wr(PI, 8'h10); rd(PD, 8'h00, "R6 untouched byte stays zero");
    sample_bit(seq_warn, 1'b0, "R8 ordered accesses no warning");

    // R8 out-of-order access
    wr(PI, 8'h85);
    rd(PA, 8'h05, "R4 alias after bare index write");
    sample_bit(seq_warn, 1'b1, "R8 warning raised");
    wr(PD, 8'h11);
    sample_bit(seq_warn, 1'b1, "R8 warning sticky");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) chk(8'(exp_q.size()), 8'h00, "monitor: reads not seen");
    finish_run();
  end
endmodule